// File: doc/BRIEF.md
# Double-Buffered PWM Compare Value Pair

This block holds two 16-bit compare values, channel A and channel B, for a PWM time-base. The waveform logic reads them from dedicated output ports. Each channel has a buffer (shadow) register and a working (active) register. Software sets each channel to one of two modes. In buffered mode, writes land in the shadow register, and the active register takes the shadow contents when a chosen time-base event occurs. In direct mode, writes go straight to the active register.

The time-base is outside this block. It supplies its count value, its period value and a clock-enable tick. A load can fire only on a tick cycle. Each channel selects its own load event: count at zero, count at period, either of the two, or never (frozen).

A small register port carries a control word and the two compare values. Address 0 is the control word, address 1 is channel A and address 2 is channel B. Each channel has a sticky flag that reports a shadow value written but not yet transferred.

Top module: `cmp_shadow_pair`

## Requirements
- R1: After a synchronous active-low reset, both active values and both shadow values are 0, both full flags are 0, and the control word reads 0x0000. This means buffered mode with load-on-zero for both channels.
- R2: The control word has this layout. Bits 1:0 are the A load select and bits 3:2 are the B load select. Bit 4 is the A mode and bit 6 is the B mode (0 buffered, 1 direct). Bit 8 is the A full flag and bit 9 is the B full flag; both are read-only. Every other bit reads 0 whatever is written. Address 3 reads 0.
- R3: In buffered mode, a write sets the shadow value on the next clock edge and leaves the active value unchanged. A read of that channel's address returns the shadow value.
- R4: Load-select encodings are 0 = count equals zero, 1 = count equals period, 2 = either, 3 = frozen. A transfer happens only in a cycle where the tick is high and the selected event matches. A frozen channel never transfers.
- R5: In direct mode, a write sets the active value on the next clock edge, and a read returns the active value. The load select has no effect, and the shadow keeps its old value.
- R6: The full flag of a channel sets on a buffered-mode write to that channel. It clears on a transfer that is not accompanied by a write.
- R7: Several writes before a transfer overwrite the shadow. Only the last value reaches the active register.
- R8: When a write and a transfer fall in the same cycle, the active register takes the old shadow value, the shadow takes the new value, and the full flag stays set.
- R9: When a control word write and a load event fall in the same cycle, the transfer decision uses the settings that were in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 A, 2 B) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| tb_tick | input | 1 | Time-base clock-enable tick |
| tb_count | input | 16 | Time-base count value |
| tb_period | input | 16 | Time-base period value |
| cmp_a_o | output | 16 | Active compare value A |
| cmp_b_o | output | 16 | Active compare value B |
| shadow_full_o | output | 2 | Full flags, bit 0 = A, bit 1 = B |

## Verification
The hardest case to reach from the ports is a write that lands in the same cycle as a matching tick. Only that timing shows whether the transfer takes the old shadow value and whether the full flag survives. The stimulus table reaches it by driving the write, the tick and a count equal to the period within a single vector. A similar vector overlaps a control word write with a zero event. The shadow left untouched under direct mode is only visible after switching back to buffered mode. The bench therefore reads it through the register port and then lets a zero event move it into the active register.

// File: rtl/cmp_shadow_pkg.sv
// Package: shared types and constants for the shadowed compare pair.
// Assumes two channels and a 16-bit control word whose field positions
// follow the per-channel stride defined below.
package cmp_shadow_pkg;

    localparam int NUM_CH   = 2;
    localparam int CTRL_W   = 16;
    localparam int ADDR_W   = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd2;

    // Control word field bases; channel i uses base + stride*i
    localparam int SEL_LSB   = 0;
    localparam int SEL_W     = 2;
    localparam int MODE_BIT  = 4;
    localparam int MODE_STEP = 2;
    localparam int FULL_BIT  = 8;

    // Event that gates the shadow-to-active transfer
    typedef enum logic [SEL_W-1:0] {
        LD_ON_ZERO   = 2'd0,
        LD_ON_PERIOD = 2'd1,
        LD_ON_EITHER = 2'd2,
        LD_FROZEN    = 2'd3
    } load_sel_e;

endpackage

// File: rtl/cmp_event_detect.sv
// Module: qualifies time-base events with the tick.
// Assumes the count and period are stable in any cycle where the tick is high.
module cmp_event_detect #(
    parameter int CNT_W = 16
) (
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             at_zero_o,
    output logic             at_period_o
);

    // Event match, valid only on tick cycles
    always_comb begin
        at_zero_o   = tick_i && (count_i == '0);
        at_period_o = tick_i && (count_i == period_i);
    end

endmodule

// File: rtl/cmp_ctrl_reg.sv
// Module: holds the writable fields of the control word, per channel.
// Assumes that writes are qualified by the address decode in the parent.
// Read-only flags are merged in by the parent.
module cmp_ctrl_reg
    import cmp_shadow_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output load_sel_e         sel_o  [N],
    output logic [N-1:0]      imm_o
);

    load_sel_e    sel_q [N];
    logic [N-1:0] imm_q;

    for (genvar i = 0; i < N; i++) begin : g_fld
        localparam int SL = SEL_LSB + SEL_W * i;
        localparam int MB = MODE_BIT + MODE_STEP * i;

        // Field registers: load on control write, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[i] <= LD_ON_ZERO;
                imm_q[i] <= 1'b0;
            end else if (wr_i) begin
                sel_q[i] <= load_sel_e'(wdata_i[SL +: SEL_W]);
                imm_q[i] <= wdata_i[MB];
            end
        end

        assign sel_o[i] = sel_q[i];
    end

    assign imm_o = imm_q;

endmodule

// File: rtl/cmp_channel.sv
// Module: one compare channel with shadow and active registers.
// Assumes the event inputs are already qualified by the tick.
// A transfer uses the mode and select values held at the clock edge.
module cmp_channel
    import cmp_shadow_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              imm_i,
    input  load_sel_e         sel_i,
    input  logic              at_zero_i,
    input  logic              at_period_i,
    output logic [DATA_W-1:0] active_o,
    output logic [DATA_W-1:0] rd_o,
    output logic              full_o
);

    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] active_q;
    logic              full_q;
    logic              ev_match;
    logic              load_stb;
    logic              wr_shadow;
    logic              wr_active;

    // Select the event that this channel listens to
    always_comb begin
        unique case (sel_i)
            LD_ON_ZERO:   ev_match = at_zero_i;
            LD_ON_PERIOD: ev_match = at_period_i;
            LD_ON_EITHER: ev_match = at_zero_i || at_period_i;
            default:      ev_match = 1'b0;
        endcase
    end

    // Strobe and write steering
    always_comb begin
        load_stb  = !imm_i && ev_match;
        wr_shadow = wr_i && !imm_i;
        wr_active = wr_i && imm_i;
    end

    // Shadow register: buffered-mode writes only
    always_ff @(posedge clk) begin
        if (!rst_n)         shadow_q <= '0;
        else if (wr_shadow) shadow_q <= wdata_i;
    end

    // Active register: direct writes or transfer of the old shadow
    always_ff @(posedge clk) begin
        if (!rst_n)         active_q <= '0;
        else if (wr_active) active_q <= wdata_i;
        else if (load_stb)  active_q <= shadow_q;
    end

    // Sticky full flag: a write wins over a same-cycle transfer
    always_ff @(posedge clk) begin
        if (!rst_n)         full_q <= 1'b0;
        else if (wr_shadow) full_q <= 1'b1;
        else if (load_stb)  full_q <= 1'b0;
    end

    assign active_o = active_q;
    assign rd_o     = imm_i ? active_q : shadow_q;
    assign full_o   = full_q;

    AST_IMM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_i && !wr_i) |=> $stable(active_q)); // R5
    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_i && sel_i == LD_FROZEN) |=> $stable(active_q)); // R4
    AST_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !imm_i) |=> full_q); // R6
    AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !wr_i) |=> !full_q); // R6
    AST_LOAD_OLD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (active_q == $past(shadow_q))); // R8
    AST_NO_TICK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_i && !at_zero_i && !at_period_i) |=> $stable(active_q)); // R4

endmodule

// File: rtl/cmp_shadow_pair.sv
// Module: top of the shadowed compare pair; register decode and read mux.
// Assumes single-cycle register writes and combinational reads.
// Channel 0 is A and channel 1 is B.
module cmp_shadow_pair
    import cmp_shadow_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              tb_tick,
    input  logic [DATA_W-1:0] tb_count,
    input  logic [DATA_W-1:0] tb_period,
    output logic [DATA_W-1:0] cmp_a_o,
    output logic [DATA_W-1:0] cmp_b_o,
    output logic [1:0]        shadow_full_o
);

    localparam int N = NUM_CH;

    load_sel_e         sel    [N];
    logic [N-1:0]      imm;
    logic [N-1:0]      ch_wr;
    logic [N-1:0]      full;
    logic [DATA_W-1:0] active [N];
    logic [DATA_W-1:0] rd_val [N];
    logic              at_zero;
    logic              at_period;
    logic [CTRL_W-1:0] ctrl_rd;

    cmp_event_detect #(.CNT_W(DATA_W)) u_evt (
        .tick_i      (tb_tick),
        .count_i     (tb_count),
        .period_i    (tb_period),
        .at_zero_o   (at_zero),
        .at_period_o (at_period)
    );

    cmp_ctrl_reg #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr && bus_addr == ADDR_CTRL),
        .wdata_i (bus_wdata),
        .sel_o   (sel),
        .imm_o   (imm)
    );

    for (genvar i = 0; i < N; i++) begin : g_ch
        // Address decode for this channel's compare register
        assign ch_wr[i] = bus_wr && (bus_addr == ADDR_CMPA + ADDR_W'(i));

        cmp_channel #(.DATA_W(DATA_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (ch_wr[i]),
            .wdata_i     (bus_wdata[DATA_W-1:0]),
            .imm_i       (imm[i]),
            .sel_i       (sel[i]),
            .at_zero_i   (at_zero),
            .at_period_i (at_period),
            .active_o    (active[i]),
            .rd_o        (rd_val[i]),
            .full_o      (full[i])
        );
    end

    // Assemble the control word with reserved bits held at zero
    always_comb begin
        ctrl_rd = '0;
        for (int i = 0; i < N; i++) begin
            ctrl_rd[SEL_LSB + SEL_W*i +: SEL_W] = sel[i];
            ctrl_rd[MODE_BIT + MODE_STEP*i]    = imm[i];
            ctrl_rd[FULL_BIT + i]              = full[i];
        end
    end

    // Read mux over the register addresses
    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_rd;
            ADDR_CMPA: bus_rdata = 16'(rd_val[0]);
            ADDR_CMPB: bus_rdata = 16'(rd_val[1]);
            default:   bus_rdata = '0;
        endcase
    end

    assign cmp_a_o       = active[0];
    assign cmp_b_o       = active[1];
    assign shadow_full_o = full;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata & 16'hFCA0) == 16'h0000); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cmp_a_o == '0 && cmp_b_o == '0 && shadow_full_o == 2'b00)); // R1

endmodule

// File: tb/sim_cmp_shadow_pair.sv
`timescale 1ns/1ps
// Bench: a stimulus table walked by one loop, then directed tests.
module sim_cmp_shadow_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        tb_tick = 1'b0;
    logic [15:0] tb_count = 16'h0;
    logic [15:0] tb_period = 16'd100;
    logic [15:0] cmp_a_o;
    logic [15:0] cmp_b_o;
    logic [1:0]  shadow_full_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_shadow_pair u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_tick(tb_tick),
        .tb_count(tb_count), .tb_period(tb_period), .cmp_a_o(cmp_a_o),
        .cmp_b_o(cmp_b_o), .shadow_full_o(shadow_full_o)
    );

    // Vector: wr, addr, wdata, tick, count, exp A, exp B, exp flags {B,A}
    localparam int NV = 15;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 2'd1, 16'h1111, 1'b0, 16'd5,   16'h0000, 16'h0000, 2'b01}, // R3 R6
        {1'b0, 2'd0, 16'h0000, 1'b1, 16'd0,   16'h1111, 16'h0000, 2'b00}, // R4 zero
        {1'b1, 2'd2, 16'h2222, 1'b1, 16'd50,  16'h1111, 16'h0000, 2'b10}, // R3
        {1'b1, 2'd0, 16'h0005, 1'b1, 16'd0,   16'h1111, 16'h2222, 2'b00}, // R9
        {1'b1, 2'd1, 16'h3333, 1'b1, 16'd0,   16'h1111, 16'h2222, 2'b01}, // R4 period
        {1'b0, 2'd0, 16'h0000, 1'b0, 16'd100, 16'h1111, 16'h2222, 2'b01}, // R4 no tick
        {1'b0, 2'd0, 16'h0000, 1'b1, 16'd100, 16'h3333, 16'h2222, 2'b00}, // R4 period
        {1'b1, 2'd0, 16'h000E, 1'b0, 16'd7,   16'h3333, 16'h2222, 2'b00}, // R2
        {1'b1, 2'd2, 16'h4444, 1'b1, 16'd0,   16'h3333, 16'h2222, 2'b10}, // R4 frozen
        {1'b0, 2'd0, 16'h0000, 1'b1, 16'd100, 16'h3333, 16'h2222, 2'b10}, // R4 frozen
        {1'b1, 2'd1, 16'h5555, 1'b1, 16'd100, 16'h3333, 16'h2222, 2'b11}, // R8
        {1'b0, 2'd0, 16'h0000, 1'b1, 16'd0,   16'h5555, 16'h2222, 2'b10}, // R4 either
        {1'b1, 2'd0, 16'h0050, 1'b0, 16'd3,   16'h5555, 16'h2222, 2'b10}, // R5
        {1'b1, 2'd2, 16'h6666, 1'b0, 16'd3,   16'h5555, 16'h6666, 2'b10}, // R5
        {1'b0, 2'd0, 16'h0000, 1'b1, 16'd0,   16'h5555, 16'h6666, 2'b10}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] addr, input logic [15:0] wd,
                        input logic tick, input logic [15:0] cnt);
        @(negedge clk);
        bus_wr = wr; bus_addr = addr; bus_wdata = wd; tb_tick = tick; tb_count = cnt;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; tb_tick = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] addr, input logic [15:0] exp);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = addr;
        #1;
        check(req, {16'h0, bus_rdata}, {16'h0, exp});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 cmp A", {16'h0, cmp_a_o}, 32'h0);
        check("R1 cmp B", {16'h0, cmp_b_o}, 32'h0);
        check("R1 flags", {30'h0, shadow_full_o}, 32'h0);
        read_chk("R1 ctrl", 2'd0, 16'h0000);
        @(negedge clk) rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [69:0] v;
            v = VEC[k];
            step(v[69], v[68:67], v[66:51], v[50], v[49:34]);
            check($sformatf("vec%0d R3-8 cmp A", k), {16'h0, cmp_a_o}, {16'h0, v[33:18]});
            check($sformatf("vec%0d R3-8 cmp B", k), {16'h0, cmp_b_o}, {16'h0, v[17:2]});
            check($sformatf("vec%0d R6 flags", k), {30'h0, shadow_full_o}, {30'h0, v[1:0]});
        end

        // R2 control read with B full flag set, both direct
        read_chk("R2 ctrl readback", 2'd0, 16'h0250);
        // R5 direct-mode reads return active
        read_chk("R5 read A", 2'd1, 16'h5555);
        read_chk("R5 read B", 2'd2, 16'h6666);
        // R2 reserved bits read 0
        step(1'b1, 2'd0, 16'hFFFF, 1'b0, 16'd9);
        read_chk("R2 reserved mask", 2'd0, 16'h025F);
        read_chk("R2 addr 3", 2'd3, 16'h0000);
        // R3 back to buffered: shadow kept during direct mode
        step(1'b1, 2'd0, 16'h0000, 1'b0, 16'd9);
        read_chk("R3 read B shadow", 2'd2, 16'h4444);
        read_chk("R3 read A shadow", 2'd1, 16'h5555);
        // R7 two writes before transfer, last one wins
        step(1'b1, 2'd1, 16'h7001, 1'b0, 16'd9);
        step(1'b1, 2'd1, 16'h7002, 1'b0, 16'd9);
        check("R7 active unchanged", {16'h0, cmp_a_o}, {16'h0, 16'h5555});
        step(1'b0, 2'd0, 16'h0000, 1'b1, 16'd0);
        check("R7 last value A", {16'h0, cmp_a_o}, {16'h0, 16'h7002});
        check("R6 B loads pending", {16'h0, cmp_b_o}, {16'h0, 16'h4444});
        check("R6 flags cleared", {30'h0, shadow_full_o}, 32'h0);
        // R1 reset in mid-run
        step(1'b1, 2'd2, 16'h9999, 1'b0, 16'd9);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 mid reset A", {16'h0, cmp_a_o}, 32'h0);
        check("R1 mid reset flags", {30'h0, shadow_full_o}, 32'h0);
        read_chk("R1 mid reset shadow B", 2'd2, 16'h0000);
        done = 1'b1;
        finish_run();
    end

endmodule